// File: doc/BRIEF.md
# Received Frame Kind Classifier

This block watches the receive side of a 64-bit streaming bus that carries Ethernet frames with every frame aligned to the most significant byte lane at its start beat. Within a beat, byte k of the beat sits in bits `[63-8k -: 8]`, so frame byte 0 is `in_data[63:56]` of the start beat. The block only observes the bus. It picks out the Length/Type field (frame bytes 12-13), the word after it (bytes 14-15, which is the control opcode or the VLAN tag control word), and the word after that (bytes 16-17, the inner type of a tagged frame). These fields can straddle beat boundaries, and the stream may drop its valid between beats.

One clock after each valid end-of-packet beat, the block pulses a status strobe together with a 40-bit kind word. The word marks MAC control frames, PAUSE and priority flow control requests, single-tagged frames and double-tagged frames. All unused bits of the word are zero. Downstream logic latches the word on the strobe, for example to steer control frames away from the data path.

A four-state machine counts header beats. `HS_IDLE` waits for a start beat. `HS_LANE1` expects the second beat, which holds bytes 8-15. `HS_LANE2` expects the third beat, which holds bytes 16-23. `HS_TAIL` passes the remaining payload. The machine has the following transitions:
- A valid start beat without end leads to `HS_LANE1`.
- A valid start beat with end leads to `HS_IDLE`.
- A valid end beat leads to `HS_IDLE`.
- A valid middle beat moves `HS_LANE1` to `HS_LANE2`, moves `HS_LANE2` to `HS_TAIL`, and leaves `HS_TAIL` in `HS_TAIL`.
- A cycle with valid low holds the state.

Top module: `rx_frame_kind_decoder`

## Requirements
- R1: `out_stat_valid` is high for exactly one cycle, in the cycle after each beat with `in_valid` and `in_eop` both high, and is low in every other cycle. After reset it is low and `out_stat` is zero.
- R2: Bit 34 of `out_stat` is set when frame bytes 12-13 equal 0x8808 (MAC control).
- R3: Bit 35 is set when the frame is a MAC control frame and bytes 14-15 equal 0x0001 (PAUSE).
- R4: Bit 39 is set when the frame is a MAC control frame and bytes 14-15 equal 0x0101 (priority flow control). A control frame with any other opcode sets only bit 34.
- R5: Bit 33 is set when bytes 12-13 equal 0x8100 (tagged frame).
- R6: Bit 32 is set when bytes 12-13 equal 0x88A8, or when bytes 12-13 and bytes 16-17 both equal 0x8100 (double-tagged frame). The second case also sets bit 33.
- R7: Bits 38:36 and 31:0 are always zero. A frame whose type matches none of the codes above reports all bits zero.
- R8: Cycles with `in_valid` low are ignored. A frame sent with idle gaps between its beats reports the same word as the same frame sent without gaps.
- R9: Captured header fields clear at every start beat. A frame that ends in its start beat reports all bits zero, even right after a flagged frame. Header bytes beyond the frame's last beat are treated as zero.
- R10: `out_stat` holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat qualifier |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_data | input | 64 | Beat data, frame byte 0 at bits 63:56 of the start beat |
| out_stat_valid | output | 1 | One-cycle strobe after each end beat |
| out_stat | output | 40 | Frame kind word: 39 PFC, 35 PAUSE, 34 control, 33 tagged, 32 double-tagged |

## Verification
The assertions take for granted a well-formed stream:
- A start beat opens every frame.
- `in_sop` and `in_eop` are only meaningful while `in_valid` is high.
- No end beat arrives outside a frame.

The bench keeps within these assumptions. It drives every frame as a start beat, middle beats and one end beat, and it lowers all three flags during gap cycles and between frames. Padding bytes past the frame length are zero, so the expected word follows directly from the frame bytes the bench builds.

// File: rtl/rxk_pkg.sv
package rxk_pkg;
    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_LANE1 = 2'd1,
        HS_LANE2 = 2'd2,
        HS_TAIL  = 2'd3
    } hdr_state_t;

    localparam int STAT_W    = 40;
    localparam int BIT_PFC   = 39;
    localparam int BIT_PAUSE = 35;
    localparam int BIT_CTRL  = 34;
    localparam int BIT_TAG   = 33;
    localparam int BIT_STACK = 32;

    localparam logic [15:0] ETY_CTRL  = 16'h8808;
    localparam logic [15:0] ETY_TAG   = 16'h8100;
    localparam logic [15:0] ETY_STACK = 16'h88A8;
    localparam logic [15:0] OPC_PAUSE = 16'h0001;
    localparam logic [15:0] OPC_PFC   = 16'h0101;
endpackage

// File: rtl/rxk_hdr_capture.sv
module rxk_hdr_capture
    import rxk_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int FIELD_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [DATA_W-1:0]  in_data,
    output logic [FIELD_W-1:0] type_now,
    output logic [FIELD_W-1:0] word_now,
    output logic [FIELD_W-1:0] inner_now
);
    // byte 12 sits in lane 4 of the second beat, byte 16 in lane 0 of the third
    localparam int TYPE_HI  = DATA_W / 2 - 1;
    localparam int WORD_HI  = TYPE_HI - FIELD_W;
    localparam int INNER_HI = DATA_W - 1;

    hdr_state_t state_q, state_d;
    logic [FIELD_W-1:0] type_q, word_q, inner_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (in_valid) begin
            if (in_sop)      state_d = in_eop ? HS_IDLE : HS_LANE1;
            else if (in_eop) state_d = HS_IDLE;
            else begin
                unique case (state_q)
                    HS_IDLE:  state_d = HS_IDLE;
                    HS_LANE1: state_d = HS_LANE2;
                    HS_LANE2: state_d = HS_TAIL;
                    HS_TAIL:  state_d = HS_TAIL;
                endcase
            end
        end
    end

    always_comb begin
        type_now  = type_q;
        word_now  = word_q;
        inner_now = inner_q;
        if (in_valid) begin
            if (in_sop) begin
                type_now  = '0;
                word_now  = '0;
                inner_now = '0;
            end else begin
                unique case (state_q)
                    HS_LANE1: begin
                        type_now = in_data[TYPE_HI -: FIELD_W];
                        word_now = in_data[WORD_HI -: FIELD_W];
                    end
                    HS_LANE2: inner_now = in_data[INNER_HI -: FIELD_W];
                    HS_IDLE, HS_TAIL: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_q  <= '0;
            word_q  <= '0;
            inner_q <= '0;
        end else begin
            type_q  <= type_now;
            word_q  <= word_now;
            inner_q <= inner_now;
        end
    end

    // R9
    sop_opens_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop && !in_eop) |=> (state_q == HS_LANE1));

    // R8
    gap_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(state_q) && $stable(type_q) && $stable(inner_q)));

    // R9
    sop_clears_inner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop) |=> (inner_q == '0));
endmodule

// File: rtl/rxk_classify.sv
module rxk_classify
    import rxk_pkg::*;
#(
    parameter int FIELD_W = 16
) (
    input  logic [FIELD_W-1:0] type_now,
    input  logic [FIELD_W-1:0] word_now,
    input  logic [FIELD_W-1:0] inner_now,
    output logic [STAT_W-1:0]  stat_now
);
    logic is_ctrl, is_tag;

    always_comb begin
        is_ctrl  = (type_now == ETY_CTRL);
        is_tag   = (type_now == ETY_TAG);
        stat_now = '0;
        stat_now[BIT_CTRL]  = is_ctrl;
        stat_now[BIT_PAUSE] = is_ctrl && (word_now == OPC_PAUSE);
        stat_now[BIT_PFC]   = is_ctrl && (word_now == OPC_PFC);
        stat_now[BIT_TAG]   = is_tag;
        stat_now[BIT_STACK] = (type_now == ETY_STACK) || (is_tag && (inner_now == ETY_TAG));
    end
endmodule

// File: rtl/rx_frame_kind_decoder.sv
module rx_frame_kind_decoder
    import rxk_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int FIELD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_stat_valid,
    output logic [39:0]       out_stat
);
    logic [FIELD_W-1:0] type_now, word_now, inner_now;
    logic [STAT_W-1:0]  stat_now;
    logic               end_beat;

    assign end_beat = in_valid && in_eop;

    rxk_hdr_capture #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_data   (in_data),
        .type_now  (type_now),
        .word_now  (word_now),
        .inner_now (inner_now)
    );

    rxk_classify #(.FIELD_W(FIELD_W)) u_classify (
        .type_now  (type_now),
        .word_now  (word_now),
        .inner_now (inner_now),
        .stat_now  (stat_now)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_stat_valid <= 1'b0;
            out_stat       <= '0;
        end else begin
            out_stat_valid <= end_beat;
            if (end_beat) out_stat <= stat_now;
        end
    end

    // R1
    strobe_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_beat |=> out_stat_valid);

    // R1
    no_stray_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !end_beat |=> !out_stat_valid);

    // R3
    flow_needs_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stat_valid && (out_stat[BIT_PAUSE] || out_stat[BIT_PFC])) |-> out_stat[BIT_CTRL]);

    // R4
    pause_pfc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_stat[BIT_PAUSE], out_stat[BIT_PFC]}));

    // R10
    word_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !end_beat |=> $stable(out_stat));
endmodule

// File: tb/test_rx_frame_kind_decoder.sv
module test_rx_frame_kind_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic [63:0] in_data = '0;
    logic        out_stat_valid;
    logic [39:0] out_stat;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [7:0] fb [0:127];
    int         flen;

    always #2 clk = ~clk;

    rx_frame_kind_decoder i_rx_frame_kind_decoder (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_sop         (in_sop),
        .in_eop         (in_eop),
        .in_data        (in_data),
        .out_stat_valid (out_stat_valid),
        .out_stat       (out_stat)
    );

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic build(input int len, input logic [15:0] ty, input logic [15:0] wd,
                         input logic [15:0] inr);
        for (int i = 0; i < 128; i++) fb[i] = 8'h00;
        for (int i = 0; i < 128; i++) fb[i] = (i < 12) ? 8'(8'hA0 + i) : 8'h5A;
        fb[12] = ty[15:8];  fb[13] = ty[7:0];
        fb[14] = wd[15:8];  fb[15] = wd[7:0];
        fb[16] = inr[15:8]; fb[17] = inr[7:0];
        for (int i = len; i < 128; i++) fb[i] = 8'h00;
        flen = len;
    endtask

    function automatic logic [39:0] expect_word();
        logic [15:0] t, w, n;
        logic [39:0] e;
        t = {fb[12], fb[13]};
        w = {fb[14], fb[15]};
        n = {fb[16], fb[17]};
        e = '0;
        e[34] = (t == 16'h8808);
        e[35] = (t == 16'h8808) && (w == 16'h0001);
        e[39] = (t == 16'h8808) && (w == 16'h0101);
        e[33] = (t == 16'h8100);
        e[32] = (t == 16'h88A8) || ((t == 16'h8100) && (n == 16'h8100));
        return e;
    endfunction

    task automatic send_and_check(input string req, input int gap);
        int nb;
        logic [39:0] e;
        nb = (flen + 7) / 8;
        e  = expect_word();
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (b == 0);
            in_eop   = (b == nb - 1);
            for (int k = 0; k < 8; k++) in_data[63 - 8*k -: 8] = fb[8*b + k];
            if (b == 1) chk({req, " R1 no strobe mid-frame"}, {39'b0, out_stat_valid}, 40'd0);
            if (gap > 0 && b < nb - 1) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
                    in_data  = {8{8'hEE}};
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
        chk({req, " R1 strobe"}, {39'b0, out_stat_valid}, 40'd1);
        chk({req, " word"}, out_stat, e);
        @(negedge clk);
        chk({req, " R1 single pulse"}, {39'b0, out_stat_valid}, 40'd0);
        chk({req, " R10 hold"}, out_stat, e);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset strobe", {39'b0, out_stat_valid}, 40'd0);
        chk("R1 reset word", out_stat, 40'd0);
    endtask

    task automatic t_plain();
        build(64, 16'h0800, 16'h4500, 16'h0000);
        send_and_check("R7 plain type", 0);
    endtask

    task automatic t_ctrl_other();
        build(64, 16'h8808, 16'h0002, 16'h0000);
        send_and_check("R2 R4 control other opcode", 0);
    endtask

    task automatic t_pause();
        build(64, 16'h8808, 16'h0001, 16'hFFFF);
        send_and_check("R3 pause", 0);
    endtask

    task automatic t_pfc();
        build(64, 16'h8808, 16'h0101, 16'h00FF);
        send_and_check("R4 pfc", 0);
    endtask

    task automatic t_vlan();
        build(72, 16'h8100, 16'h0123, 16'h0800);
        send_and_check("R5 tagged", 0);
    endtask

    task automatic t_stack_ad();
        build(72, 16'h88A8, 16'h0064, 16'h8100);
        send_and_check("R6 double tag 88A8", 0);
    endtask

    task automatic t_stack_double();
        build(80, 16'h8100, 16'h0064, 16'h8100);
        send_and_check("R6 double 8100", 0);
    endtask

    task automatic t_gaps();
        build(64, 16'h8808, 16'h0001, 16'h0000);
        send_and_check("R8 pause with gaps", 2);
        build(40, 16'h8100, 16'h0005, 16'h8100);
        send_and_check("R8 double tag with gaps", 1);
    endtask

    task automatic t_short();
        build(64, 16'h8808, 16'h0101, 16'h0000);
        send_and_check("R9 pfc before short", 0);
        build(8, 16'h0000, 16'h0000, 16'h0000);
        send_and_check("R9 single-beat frame", 0);
        build(16, 16'h8100, 16'h0007, 16'h8100);
        send_and_check("R9 two-beat tagged frame", 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_plain();
        t_ctrl_other();
        t_pause();
        t_pfc();
        t_vlan();
        t_stack_ad();
        t_stack_double();
        t_gaps();
        t_short();
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule